// File: doc/BRIEF.md
# Page-Mode External Memory Bus Controller

This block turns single read or write requests from a core into cycles on an external bus. The bus is two byte-wide ports, called bus A and bus B. Each port has its own output value and output enable, and shares one input. An address strobe marks the cycles in which an external latch captures an address byte. Read and write strobes mark the data phase. A one-cycle `done` pulse ends every access, and read data is returned with it.

A small control register picks the bus scheme. With paging off, the controller uses the classic latched-address bus:

- Bus B carries the upper address byte for the whole access.
- Bus A carries the lower address byte and then the data.

With paging on, the controller remembers the upper address byte of the last paged access. An access to that same upper byte is a page hit and skips the upper-address phase. Any other access is a miss and runs the full sequence. The select field sets the base length of an access and also the port scheme:

- Split-A scheme: bus A carries data only, and bus B carries the upper and then the lower address byte.
- Split-B scheme: bus A carries only the lower address byte, and bus B carries the upper address byte and then data.

The sequencer has four states: IDLE, ALAT, PAGE and XFER. A request in IDLE goes to one of three states:

- ALAT, when paging is off.
- PAGE, on a page miss.
- XFER directly, on a page hit.

The other transitions are:

- ALAT lasts one cycle and moves to XFER.
- PAGE lasts the base length and moves to XFER.
- XFER lasts the base length (two cycles for the classic bus) and returns to IDLE, raising `done` at that edge.

Requests are accepted only in IDLE.

Top module: `xbus_pager`

## Requirements
- R1: After reset the control register reads 8'h1F, which means paging off (bit 7 = 0), select 00 (bits 6..5), and bits 4..0 reading 1. After reset `done` is low and both port output enables are low. Bits 4..0 read 1 at all times.
- R2: A control-register write takes effect only when `cfg_ta` is high in the same cycle as `cfg_we`. Without `cfg_ta` the register keeps its value and the stored page is kept.
- R3: With paging off, `done` rises 3 clock edges after the edge that accepts the request. In the first cycle, bus A drives the lower address byte, bus B drives the upper byte, and `adr_stb` is high. Bus B keeps the upper byte during the data phase, and data moves on bus A.
- R4: With paging on, `done` rises N edges after the accepting edge. For select 00, 01, 10 and 11, N is 1, 2, 4 and 2 on a hit, and 2, 4, 8 and 4 on a miss.
- R5: Select values 00, 01 and 10 use the split-A scheme. In the first hit-phase cycle, bus B drives the lower address byte with `adr_stb` high. Data moves on bus A.
- R6: Select 11 uses the split-B scheme. Bus A drives the lower address byte in every cycle of the access, and data moves on bus B.
- R7: On a miss, the first cycle drives the upper address byte on bus B with `adr_stb` high, and that byte is stored. A following access with the same upper byte is a hit.
- R8: After reset and after every accepted control-register write (even one with an unchanged value), the next paged access is a miss.
- R9: During a read's data phase, `rd_stb` is high and the data-carrying port's output enable stays low. `rdata` shows that port's input, sampled at the last data-phase edge, while `done` is high.
- R10: During a write's data phase, `wr_stb` is high and the data-carrying port drives the write byte with its output enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write request |
| cfg_ta | input | 1 | Timed-access qualifier for the write |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register read value |
| req | input | 1 | Access request, taken in IDLE |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| pa_i | input | 8 | Bus A input |
| pb_i | input | 8 | Bus B input |
| pa_o | output | 8 | Bus A drive value |
| pa_oe | output | 1 | Bus A output enable |
| pb_o | output | 8 | Bus B drive value |
| pb_oe | output | 1 | Bus B output enable |
| adr_stb | output | 1 | Address latch strobe |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| done | output | 1 | One-cycle access completion pulse |
| rdata | output | 8 | Read data, valid with done |

## Verification
The hardest case to reach is one where the page store must survive a control-register write that was refused. That only shows up as a hit-length access where a miss would otherwise occur. The stimulus first establishes a page with a miss, then issues an unqualified write, then accesses the same page and measures the hit latency. After that it repeats the write with the qualifier and the same value, and expects the full miss latency. Every select value is swept through miss, hit, write-hit, page-change and return-to-old-page accesses, with the expected latency computed from the select field.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALAT,
        ST_PAGE,
        ST_XFER
    } xb_state_e;

    typedef enum logic [1:0] {
        BM_STD,
        BM_SPLIT_A,
        BM_SPLIT_B
    } xb_mode_e;

    typedef struct packed {
        logic       en;
        logic [1:0] sel;
    } xb_cfg_t;

endpackage

// File: rtl/xbus_cfg_reg.sv
module xbus_cfg_reg
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       ta,
    input  logic [2:0] wval,
    output xb_cfg_t    cfg,
    output logic [7:0] rval,
    output logic       upd
);

    assign upd = we && ta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (upd) begin
            cfg <= wval;
        end
    end

    assign rval = {cfg.en, cfg.sel, 5'b11111};

    // R2: unqualified write leaves the register untouched
    p_ta_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ta) |=> $stable(cfg));

endmodule

// File: rtl/xbus_page_tag.sv
module xbus_page_tag #(
    parameter int MSBW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            load,
    input  logic [MSBW-1:0] msb_in,
    output logic            hit
);

    logic            valid_q;
    logic [MSBW-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (flush) begin
            valid_q <= 1'b0;
        end else if (load) begin
            valid_q <= 1'b1;
            tag_q   <= msb_in;
        end
    end

    assign hit = valid_q && (tag_q == msb_in);

    // R8: accepted configuration write forgets the page
    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid_q);

    // R7: a paged access stores its upper byte
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !flush) |=> (valid_q && tag_q == $past(msb_in)));

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int MC_CLKS     = 1,
    parameter int STD_DATA_MC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xb_cfg_t       cfg,
    input  logic          hit,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] pa_i,
    input  logic [DW-1:0] pb_i,
    output logic          accept,
    output logic [DW-1:0] pa_o,
    output logic          pa_oe,
    output logic [DW-1:0] pb_o,
    output logic          pb_oe,
    output logic          adr_stb,
    output logic          rd_stb,
    output logic          wr_stb,
    output logic          done,
    output logic [DW-1:0] rdata
);

    localparam int STD_LEN = STD_DATA_MC * MC_CLKS;
    localparam int PG_MAX  = 4 * MC_CLKS;
    localparam int LMAX    = (PG_MAX > STD_LEN) ? PG_MAX : STD_LEN;
    localparam int CW      = $clog2(LMAX + 1);

    function automatic logic [CW-1:0] hit_len(input logic [1:0] s);
        case (s)
            2'b00:   return CW'(MC_CLKS);
            2'b01:   return CW'(2 * MC_CLKS);
            2'b10:   return CW'(4 * MC_CLKS);
            default: return CW'(2 * MC_CLKS);
        endcase
    endfunction

    xb_state_e     state;
    xb_mode_e      mode_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] len_q;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [CW-1:0] last;
    logic          first;

    assign accept = (state == ST_IDLE) && req;
    assign last   = (state == ST_ALAT) ? CW'(MC_CLKS - 1) : len_q - CW'(1);
    assign first  = (cnt == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_q  <= BM_STD;
            cnt     <= '0;
            len_q   <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        we_q    <= req_we;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        cnt     <= '0;
                        if (!cfg.en) begin
                            mode_q <= BM_STD;
                            len_q  <= CW'(STD_LEN);
                            state  <= ST_ALAT;
                        end else begin
                            mode_q <= (cfg.sel == 2'b11) ? BM_SPLIT_B : BM_SPLIT_A;
                            len_q  <= hit_len(cfg.sel);
                            state  <= hit ? ST_XFER : ST_PAGE;
                        end
                    end
                end
                ST_ALAT, ST_PAGE: begin
                    if (cnt == last) begin
                        cnt   <= '0;
                        state <= ST_XFER;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_XFER: begin
                    if (cnt == last) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        rdata <= (mode_q == BM_SPLIT_B) ? pb_i : pa_i;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pa_o    = '0;
        pa_oe   = 1'b0;
        pb_o    = '0;
        pb_oe   = 1'b0;
        adr_stb = 1'b0;
        rd_stb  = 1'b0;
        wr_stb  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ALAT: begin
                pa_o    = addr_q[DW-1:0];
                pa_oe   = 1'b1;
                pb_o    = addr_q[AW-1:DW];
                pb_oe   = 1'b1;
                adr_stb = 1'b1;
            end
            ST_PAGE: begin
                pb_o    = addr_q[AW-1:DW];
                pb_oe   = 1'b1;
                adr_stb = first;
                if (mode_q == BM_SPLIT_B) begin
                    pa_o  = addr_q[DW-1:0];
                    pa_oe = 1'b1;
                end
            end
            ST_XFER: begin
                rd_stb = !we_q;
                wr_stb = we_q;
                case (mode_q)
                    BM_SPLIT_A: begin
                        pb_o    = addr_q[DW-1:0];
                        pb_oe   = 1'b1;
                        adr_stb = first;
                        pa_o    = wdata_q;
                        pa_oe   = we_q;
                    end
                    BM_SPLIT_B: begin
                        pa_o  = addr_q[DW-1:0];
                        pa_oe = 1'b1;
                        pb_o  = wdata_q;
                        pb_oe = we_q;
                    end
                    default: begin
                        pb_o  = addr_q[AW-1:DW];
                        pb_oe = 1'b1;
                        pa_o  = wdata_q;
                        pa_oe = we_q;
                    end
                endcase
            end
        endcase
    end

    // R1: idle bus is released and quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!pa_oe && !pb_oe && !rd_stb && !wr_stb));

    // R9: data port never driven while a read is sampling it
    p_rd_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> ((mode_q == BM_SPLIT_B) ? !pb_oe : !pa_oe));

    // R10: write data is driven on the data port
    p_wr_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ((mode_q == BM_SPLIT_B) ? (pb_oe && pb_o == wdata_q)
                                           : (pa_oe && pa_o == wdata_q)));

    // R4: an access never overstays its length
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (cnt <= last));

endmodule

// File: rtl/xbus_pager.sv
module xbus_pager
    import xbus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int MC_CLKS     = 1,
    parameter int STD_DATA_MC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_ta,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] pa_i,
    input  logic [DW-1:0] pb_i,
    output logic [DW-1:0] pa_o,
    output logic          pa_oe,
    output logic [DW-1:0] pb_o,
    output logic          pb_oe,
    output logic          adr_stb,
    output logic          rd_stb,
    output logic          wr_stb,
    output logic          done,
    output logic [DW-1:0] rdata
);

    localparam int MSBW = AW - DW;

    xb_cfg_t cfg;
    logic    cfg_upd;
    logic    page_hit;
    logic    accept;
    logic    unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata[4:0];

    xbus_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .ta    (cfg_ta),
        .wval  (cfg_wdata[7:5]),
        .cfg   (cfg),
        .rval  (cfg_rdata),
        .upd   (cfg_upd)
    );

    xbus_page_tag #(.MSBW(MSBW)) u_tag (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (cfg_upd),
        .load   (accept && cfg.en),
        .msb_in (req_addr[AW-1:DW]),
        .hit    (page_hit)
    );

    xbus_seq #(
        .AW          (AW),
        .DW          (DW),
        .MC_CLKS     (MC_CLKS),
        .STD_DATA_MC (STD_DATA_MC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .hit       (page_hit),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .pa_i      (pa_i),
        .pb_i      (pb_i),
        .accept    (accept),
        .pa_o      (pa_o),
        .pa_oe     (pa_oe),
        .pb_o      (pb_o),
        .pb_oe     (pb_oe),
        .adr_stb   (adr_stb),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .done      (done),
        .rdata     (rdata)
    );

endmodule

// File: tb/sim_xbus_pager.sv
module sim_xbus_pager;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_ta = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  pa_i = '0;
    logic [7:0]  pb_i = '0;
    logic [7:0]  pa_o;
    logic        pa_oe;
    logic [7:0]  pb_o;
    logic        pb_oe;
    logic        adr_stb;
    logic        rd_stb;
    logic        wr_stb;
    logic        done;
    logic [7:0]  rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    xbus_pager u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ta(cfg_ta),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .pa_i(pa_i), .pb_i(pb_i), .pa_o(pa_o), .pa_oe(pa_oe),
        .pb_o(pb_o), .pb_oe(pb_oe), .adr_stb(adr_stb), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .done(done), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v, input bit ta);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_ta    = ta;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_ta = 1'b0;
    endtask

    // mode: 0 classic, 1 split-A, 2 split-B; hl = hit length
    task automatic access(input bit we, input logic [15:0] a, input logic [7:0] wd,
                          input int mode, input bit exp_hit, input int hl);
        int  n;
        int  k;
        bit  bad_rel = 0;
        bit  saw_rd = 0;
        bit  saw_wr = 0;
        bit  wr_ok = 1;
        logic [7:0] exp_rd;
        n = (mode == 0) ? 3 : (exp_hit ? hl : 2 * hl);
        pa_i = 8'h3C ^ a[7:0];
        pb_i = 8'hC3 ^ a[7:0];
        exp_rd = (mode == 2) ? pb_i : pa_i;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        k = 0;
        if (mode == 0)
            chk(adr_stb && pa_oe && pa_o == a[7:0] && pb_oe && pb_o == a[15:8],
                "R3 classic address cycle", {pa_o, pb_o}, {a[7:0], a[15:8]});
        else if (!exp_hit)
            chk(adr_stb && pb_oe && pb_o == a[15:8], "R7 miss upper byte", pb_o, a[15:8]);
        else if (mode == 1)
            chk(adr_stb && pb_oe && pb_o == a[7:0], "R5 split-A lower byte", pb_o, a[7:0]);
        if (mode == 2)
            chk(pa_oe && pa_o == a[7:0], "R6 split-B lower byte", pa_o, a[7:0]);
        while (!done && k < 40) begin
            if (rd_stb) begin
                saw_rd = 1;
                if (mode == 2 ? pb_oe : pa_oe) bad_rel = 1;
            end
            if (wr_stb) begin
                saw_wr = 1;
                if (mode == 2) begin
                    if (!(pb_oe && pb_o == wd)) wr_ok = 0;
                end else begin
                    if (!(pa_oe && pa_o == wd)) wr_ok = 0;
                end
            end
            if (mode == 0 && rd_stb && pb_o != a[15:8]) bad_rel = 1;
            if (mode == 2 && !(pa_oe && pa_o == a[7:0])) wr_ok = 0;
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        if (mode == 0) chk(k == n, "R3 classic latency", k, n);
        else           chk(k == n, exp_hit ? "R4 hit latency" : "R4 miss latency", k, n);
        if (!we) begin
            chk(saw_rd && !bad_rel, "R9 read port released", bad_rel, 0);
            chk(rdata == exp_rd, "R9 read data", rdata, exp_rd);
        end else begin
            chk(saw_wr && wr_ok && !saw_rd, "R10 write drive", wr_ok, 1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 8'h1F, "R1 reset register", cfg_rdata, 8'h1F);
        chk(!done && !pa_oe && !pb_oe, "R1 reset outputs", {done, pa_oe, pb_oe}, 0);

        access(0, 16'h1234, 8'h00, 0, 0, 0);
        access(1, 16'h1235, 8'h9D, 0, 0, 0);

        cfg_write(8'hE0, 0);
        chk(cfg_rdata == 8'h1F, "R2 unqualified write ignored", cfg_rdata, 8'h1F);
        access(0, 16'h4321, 8'h00, 0, 0, 0);

        for (int s = 0; s < 4; s++) begin
            logic [7:0] v;
            int md;
            int hl;
            v  = 8'h80 | 8'(s << 5);
            md = (s == 3) ? 2 : 1;
            hl = (s == 3) ? 2 : (1 << s);
            cfg_write(v, 1);
            chk(cfg_rdata == (v | 8'h1F), "R2 qualified write", cfg_rdata, v | 8'h1F);
            access(0, 16'h5A10, 8'h00, md, 0, hl);   // R8 first after write
            access(0, 16'h5A77, 8'h00, md, 1, hl);   // R7 same page
            access(1, 16'h5A20, 8'h6E, md, 1, hl);
            access(1, 16'h6B01, 8'h17, md, 0, hl);
            access(0, 16'h6B99, 8'h00, md, 1, hl);
            access(0, 16'h5A00, 8'h00, md, 0, hl);
            cfg_write(8'h00, 0);                       // R2 refused, page kept
            chk(cfg_rdata == (v | 8'h1F), "R2 refused write keeps value", cfg_rdata, v | 8'h1F);
            access(0, 16'h5A11, 8'h00, md, 1, hl);
            cfg_write(v, 1);                           // R8 same value flushes page
            access(1, 16'h5A12, 8'hC4, md, 0, hl);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule